// File: doc/BRIEF.md
# Secure Exception Return Context Unstacker

This block runs during exception return, before the ordinary caller-saved frame is popped. It is given a start pulse together with the exception return code, the security state being returned to and the current frame pointer. It then decides whether an extra callee-saved context sits at the base of the frame. If no extra context is present, it finishes one cycle later and hands back the frame pointer unchanged.

When an extra context must be restored, the block first reads the integrity signature word at the frame pointer through a 32-bit read port and compares it with a fixed constant. If the word does not match, the block loads nothing. It raises a fault request and a pulse that sets the invalid-state bit in the secure fault syndrome, so the fault is taken on the existing stack. If the word matches, the block reads eight words and writes them to general registers r4 to r11 through a register-file write port. The word that follows the signature is skipped. The block then reports completion with the frame pointer advanced past the extra context.

The read port is a request stream with valid/ready. The block raises `rd_req_valid` and holds both it and `rd_req_addr` steady until `rd_req_ready` is seen high at a clock edge. Back-pressure is applied by holding `rd_req_ready` low. The response arrives as a single-cycle `rd_rsp_valid` strobe carrying `rd_rsp_data`. The response path cannot be back-pressured, and only one read is outstanding at a time.

Top module: `exc_ctx_unstack`

## Requirements
- R1: After reset, `busy`, `done`, `fault`, `sfsr_invis_set`, `rf_we` and `rd_req_valid` are all low.
- R2: A start pulse triggers a context pop only when `to_secure` is 1 and at least one of `exc_ret[0]` or `exc_ret[5]` is 0.
- R3: When no pop is needed, `done` is high for one cycle, starting in the cycle right after the start pulse. `done_fp` equals the captured frame pointer, and no read request is issued.
- R4: When a pop is needed, the first read is at the frame pointer. The word returned is compared with the constant 0xFEFA125B.
- R5: On a signature mismatch, `fault` and `sfsr_invis_set` pulse together for one cycle, `done` stays low, and no register-file write is made.
- R6: On a signature match, registers 4 to 11 are written in ascending order with the words read from frame pointer offsets 0x08 to 0x24 in steps of 4. There is one write for each accepted response, and the word at offset 0x04 is never read.
- R7: After a successful pop, `done_fp` equals the captured frame pointer plus 0x28.
- R8: While `rd_req_valid` is high and `rd_req_ready` is low, the request and its address stay unchanged in the next cycle. A new request is raised only after the response to the previous one.
- R9: A start pulse that arrives while `busy` is high is ignored. The transfer in progress completes with its own frame pointer.
- R10: Each accepted start produces exactly one completion: either `done` or `fault`, never both, and never twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an unstack; captures the return code, the target state and the frame pointer |
| exc_ret | input | 32 | Exception return code (bit 0 and bit 5 are decoded) |
| to_secure | input | 1 | Return targets the secure state |
| frame_ptr | input | 32 | Frame pointer at the start of the return |
| busy | output | 1 | A transfer is in progress |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 4 | Register index being written |
| rf_wdata | output | 32 | Register write data |
| done | output | 1 | Completion pulse |
| done_fp | output | 32 | Frame pointer to use for the caller-saved pop; valid with `done` |
| fault | output | 1 | Secure fault request pulse |
| sfsr_invis_set | output | 1 | Pulse that sets the invalid-state syndrome bit |

## Verification
The assertions assume that the memory side behaves well. `rd_rsp_valid` is raised only once for each accepted request, at least one cycle after acceptance. `start` arrives only as a single-cycle pulse. The bench's memory model records each accepted request at the falling edge and returns exactly one strobe on the next cycle. It can insert ready stalls on alternate cycles so that back-pressure is exercised. Start pulses are always single-cycle, including the deliberate start issued while a transfer is busy.

// File: rtl/unstk_pkg.sv
package unstk_pkg;
  localparam logic [31:0] SIG_WORD  = 32'hFEFA_125B;
  localparam int          N_REGS    = 8;
  localparam int          FIRST_REG = 4;
  localparam int          REG_BASE  = 8;   // byte offset of the first restored word
  localparam int          POP_BYTES = 40;  // size of the extra context
  localparam int          CNT_W     = $clog2(N_REGS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } unstk_st_t;
endpackage

// File: rtl/unstk_decide.sv
module unstk_decide #(
  parameter int RW       = 32,
  parameter int ES_POS   = 0,
  parameter int DCRS_POS = 5
) (
  input  logic [RW-1:0] ret_code,
  input  logic          secure_tgt,
  output logic          need_pop
);
  always_comb begin
    need_pop = secure_tgt && (!ret_code[ES_POS] || !ret_code[DCRS_POS]);
  end
endmodule

// File: rtl/unstk_addr.sv
module unstk_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]               base,
  input  logic [unstk_pkg::CNT_W-1:0] step,
  output logic [AW-1:0]               addr
);
  import unstk_pkg::*;
  logic [AW-1:0] step_w;
  logic [AW-1:0] offs;

  always_comb begin
    step_w = {{(AW-CNT_W){1'b0}}, step};
    // step 0: signature word; step k>=1: word k of the register block
    if (step == '0) offs = '0;
    else            offs = AW'(REG_BASE) + ((step_w - AW'(1)) << 2);
    addr = base + offs;
  end
endmodule

// File: rtl/unstk_seq.sv
module unstk_seq #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           need_pop,
  input  logic [AW-1:0]  fp_in,
  output logic [AW-1:0]  fp_q,
  output logic [unstk_pkg::CNT_W-1:0] step,
  output logic           busy,
  output logic           req_valid,
  input  logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic           rsp_valid,
  input  logic [DW-1:0]  rsp_data,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata,
  output logic           done,
  output logic [AW-1:0]  done_fp,
  output logic           fault,
  output logic           invis
);
  import unstk_pkg::*;
  unstk_st_t st;
  logic      last_step;
  logic      sig_bad;

  assign last_step = (step == CNT_W'(N_REGS));
  assign sig_bad   = (step == '0) && (rsp_data != DW'(SIG_WORD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      step    <= '0;
      fp_q    <= '0;
      done    <= 1'b0;
      done_fp <= '0;
      fault   <= 1'b0;
      invis   <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      invis <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          fp_q <= fp_in;
          step <= '0;
          if (need_pop) st <= ST_REQ;
          else begin
            done    <= 1'b1;
            done_fp <= fp_in;
          end
        end
        ST_REQ: if (req_ready) st <= ST_RSP;
        ST_RSP: if (rsp_valid) begin
          if (sig_bad) begin
            fault <= 1'b1;
            invis <= 1'b1;
            st    <= ST_IDLE;
          end else if (last_step) begin
            done    <= 1'b1;
            done_fp <= fp_q + AW'(POP_BYTES);
            st      <= ST_IDLE;
          end else begin
            step <= step + 1'b1;
            st   <= ST_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    req_valid = (st == ST_REQ);
    rf_we     = (st == ST_RSP) && rsp_valid && (step != '0);
    rf_idx    = RIW'(FIRST_REG) + RIW'(step) - RIW'(1);
    rf_wdata  = rsp_data;
  end

  AST_COMPLETE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_ready) |=> (req_valid && $stable(req_addr))); // R8
  AST_INVIS_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n) invis == fault); // R5
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> (rf_idx >= RIW'(FIRST_REG) && rf_idx <= RIW'(FIRST_REG + N_REGS - 1))); // R6
  AST_NO_REQ_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !busy); // R5
  AST_WR_NOT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> !req_valid); // R8
endmodule

// File: rtl/exc_ctx_unstack.sv
module exc_ctx_unstack #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RW       = 32,
  parameter int RIW      = 4,
  parameter int ES_POS   = 0,
  parameter int DCRS_POS = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RW-1:0]  exc_ret,
  input  logic           to_secure,
  input  logic [AW-1:0]  frame_ptr,
  output logic           busy,
  output logic           rd_req_valid,
  input  logic           rd_req_ready,
  output logic [AW-1:0]  rd_req_addr,
  input  logic           rd_rsp_valid,
  input  logic [DW-1:0]  rd_rsp_data,
  output logic           rf_we,
  output logic [RIW-1:0] rf_idx,
  output logic [DW-1:0]  rf_wdata,
  output logic           done,
  output logic [AW-1:0]  done_fp,
  output logic           fault,
  output logic           sfsr_invis_set
);
  import unstk_pkg::*;
  logic              need_pop;
  logic [AW-1:0]     fp_q;
  logic [CNT_W-1:0]  step;

  unstk_decide #(.RW(RW), .ES_POS(ES_POS), .DCRS_POS(DCRS_POS)) u_decide (
    .ret_code(exc_ret), .secure_tgt(to_secure), .need_pop(need_pop)
  );

  unstk_addr #(.AW(AW)) u_addr (
    .base(fp_q), .step(step), .addr(rd_req_addr)
  );

  unstk_seq #(.AW(AW), .DW(DW), .RIW(RIW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .need_pop(need_pop),
    .fp_in(frame_ptr), .fp_q(fp_q), .step(step), .busy(busy),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .rsp_data(rd_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .done(done), .done_fp(done_fp), .fault(fault), .invis(sfsr_invis_set)
  );

  AST_NOPOP_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && !need_pop) |=> (done && !busy)); // R3
  AST_POP_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && need_pop) |=> (busy && !done)); // R2
endmodule

// File: tb/sim_exc_ctx_unstack.sv
module sim_exc_ctx_unstack;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SIG = 32'hFEFA125B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] exc_ret = '0;
  logic        to_secure = 1'b0;
  logic [31:0] frame_ptr = '0;
  logic        busy, rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr, rd_rsp_data, rf_wdata, done_fp;
  logic        rf_we, done, fault, sfsr_invis_set;
  logic [3:0]  rf_idx;

  int checks = 0, fails = 0, cyc = 0;
  logic stall_mode = 1'b0;
  logic [31:0] sig_val = SIG;
  logic [31:0] sig_addr = '0;

  int n_req, n_wr, n_done, n_fault, n_invis, done_cyc;
  logic [31:0] req_log [16];
  logic [3:0]  wi_log [16];
  logic [31:0] wd_log [16];
  logic [31:0] last_fp;

  exc_ctx_unstack u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .exc_ret(exc_ret),
    .to_secure(to_secure), .frame_ptr(frame_ptr), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .done(done), .done_fp(done_fp), .fault(fault), .sfsr_invis_set(sfsr_invis_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a == sig_addr) return sig_val;
    return a ^ 32'hC3A5_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: one strobe the cycle after an accepted request
  initial begin
    rd_req_ready = 1'b1; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    forever begin
      logic hs; logic [31:0] a;
      @(negedge clk);
      hs = rd_req_valid && rd_req_ready;
      a  = rd_req_addr;
      @(posedge clk); #1;
      rd_rsp_valid = hs;
      rd_rsp_data  = hs ? mem_word(a) : 32'h0;
      rd_req_ready = stall_mode ? ~rd_req_ready : 1'b1;
    end
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (rd_req_valid && rd_req_ready) begin
      if (n_req < 16) req_log[n_req] = rd_req_addr;
      n_req++;
    end
    if (rf_we) begin
      if (n_wr < 16) begin wi_log[n_wr] = rf_idx; wd_log[n_wr] = rf_wdata; end
      n_wr++;
    end
    if (done) begin n_done++; last_fp = done_fp; done_cyc = cyc; end
    if (fault) n_fault++;
    if (sfsr_invis_set) n_invis++;
  end

  task automatic clear_log();
    n_req = 0; n_wr = 0; n_done = 0; n_fault = 0; n_invis = 0; done_cyc = -1; last_fp = '0;
  endtask

  task automatic launch(input logic [31:0] fp, input logic [31:0] er, input logic sec,
                        output int scyc);
    @(posedge clk); #1;
    start = 1'b1; frame_ptr = fp; exc_ret = er; to_secure = sec; scyc = cyc;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pop_ok(input logic [31:0] fp, input string tag);
    chk(n_req == 9, {tag, " R6 read count"}, n_req, 9);
    chk(req_log[0] == fp, {tag, " R4 signature address"}, req_log[0], fp);
    for (int k = 0; k < 8; k++) begin
      chk(req_log[k+1] == fp + 32'd8 + 32'(4*k), {tag, " R6 read address"}, req_log[k+1], fp + 32'd8 + 32'(4*k));
      chk(req_log[k+1] != fp + 32'd4, {tag, " R6 skipped word"}, req_log[k+1], fp + 32'd4);
    end
    chk(n_wr == 8, {tag, " R6 write count"}, n_wr, 8);
    for (int k = 0; k < 8; k++) begin
      chk(wi_log[k] == 4'(4 + k), {tag, " R6 write index"}, 32'(wi_log[k]), 32'(4 + k));
      chk(wd_log[k] == ((fp + 32'd8 + 32'(4*k)) ^ 32'hC3A5_0000), {tag, " R6 write data"},
          wd_log[k], (fp + 32'd8 + 32'(4*k)) ^ 32'hC3A5_0000);
    end
    chk(n_done == 1 && n_fault == 0, {tag, " R10 one done"}, n_done, 1);
    chk(last_fp == fp + 32'h28, {tag, " R7 advanced frame pointer"}, last_fp, fp + 32'h28);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !fault && !sfsr_invis_set && !rf_we && !rd_req_valid,
        "R1 reset outputs", {26'b0, busy, done, fault, sfsr_invis_set, rf_we, rd_req_valid}, 0);
  endtask

  task automatic t_nopop(input logic [31:0] fp, input logic [31:0] er, input logic sec, input string tag);
    int s;
    clear_log();
    launch(fp, er, sec, s);
    settle();
    chk(n_req == 0, {tag, " R2 no read"}, n_req, 0);
    chk(n_done == 1 && n_fault == 0, {tag, " R10 single done"}, n_done, 1);
    chk(done_cyc == s + 1, {tag, " R3 done latency"}, done_cyc - s, 1);
    chk(last_fp == fp, {tag, " R3 frame pointer unchanged"}, last_fp, fp);
    chk(n_wr == 0, {tag, " R3 no writes"}, n_wr, 0);
  endtask

  task automatic t_pop_ok(input logic [31:0] fp, input logic [31:0] er, input logic stall, input string tag);
    int s;
    clear_log();
    stall_mode = stall; sig_addr = fp; sig_val = SIG;
    launch(fp, er, 1'b1, s);
    settle();
    expect_pop_ok(fp, tag);
    stall_mode = 1'b0;
  endtask

  task automatic t_pop_bad(input logic [31:0] fp);
    int s;
    clear_log();
    sig_addr = fp; sig_val = SIG ^ 32'h1;
    launch(fp, 32'h0000_0000, 1'b1, s);
    settle();
    chk(n_req == 1 && req_log[0] == fp, "R4 only signature read", n_req, 1);
    chk(n_fault == 1, "R5 fault pulse", n_fault, 1);
    chk(n_invis == 1, "R5 syndrome pulse", n_invis, 1);
    chk(n_wr == 0, "R5 no register writes", n_wr, 0);
    chk(n_done == 0, "R10 no done on fault", n_done, 0);
    sig_val = SIG;
  endtask

  task automatic t_busy_start(input logic [31:0] fp);
    int s;
    clear_log();
    sig_addr = fp; sig_val = SIG;
    launch(fp, 32'hFFFF_FFDE, 1'b1, s);
    @(posedge clk); #1;
    chk(busy, "R9 busy during pop", busy, 1);
    start = 1'b1; frame_ptr = 32'h0000_9000; exc_ret = 32'hFFFF_FFFF; to_secure = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    settle();
    expect_pop_ok(fp, "R9 busy start ignored");
  endtask

  initial begin
    bit timed_out = 0;
    fork
      begin
        clear_log();
        repeat (3) @(posedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        t_nopop(32'h2000_1000, 32'h0000_0000, 1'b0, "R2 nonsecure target");
        t_nopop(32'h2000_1100, 32'hFFFF_FFFF, 1'b1, "R2 secure both bits set");
        t_pop_ok(32'h2000_2000, 32'hFFFF_FFFE, 1'b0, "R2 es clear");
        t_pop_ok(32'h2000_3000, 32'hFFFF_FFDF, 1'b1, "R8 dcrs clear stalled");
        t_pop_bad(32'h2000_4000);
        t_pop_ok(32'h2000_5000, 32'h0000_0000, 1'b1, "R6 both clear stalled");
        t_busy_start(32'h2000_6000);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule